// File: doc/BRIEF.md
# Restoring Array Divider

This block divides an unsigned dividend by an unsigned divisor in a single combinational pass. The default widths are a 6-bit dividend and a 3-bit divisor. The hardware is a grid of identical divider cells, with one row for each quotient bit. The first row handles the most significant dividend bit.

Each row forms a trial remainder and subtracts the divisor from it with a ripple of full subtractors. The borrow out of the row's top position gives that row's quotient bit. A multiplexer in each cell then chooses what goes on to the next row:
- if the trial subtraction did not go negative, the difference;
- otherwise, the untouched trial remainder, which restores it.

Each cell hands its divisor bit to the next row unchanged. Each row also brings in one new dividend bit, so the divisor moves one column to the right relative to the partial remainder on every row.

A sign stage sits beside the unsigned core and can be enabled by a parameter. It treats the operands as sign-magnitude values and derives one sign for the quotient and the remainder. A zero divisor is flagged on its own output. In that case the quotient and remainder follow a fixed rule, given below.

Top module: `restoring_array_divider`

## Requirements
- R1: For a non-zero divisor, `quotient` equals the dividend magnitude divided by the divisor magnitude, rounded down.
- R2: For a non-zero divisor, `remainder` equals the dividend magnitude modulo the divisor magnitude.
- R3: For a non-zero divisor, `remainder` is strictly less than `divisor`, and `quotient * divisor + remainder` equals `dividend`.
- R4: `div_by_zero` is 1 exactly when `divisor` is all zeros.
- R5: When `divisor` is zero, `quotient` is all ones and `remainder` equals the low divisor-width bits of `dividend`.
- R6: With the sign stage enabled (the default), `quotient_sign` and `remainder_sign` are always equal, and both are the XOR of `dividend_sign` and `divisor_sign`.
- R7: The sign inputs have no effect on `quotient`, `remainder` or `div_by_zero`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dividend | input | DW | Dividend magnitude |
| divisor | input | VW | Divisor magnitude |
| dividend_sign | input | 1 | Sign of the dividend (1 = negative) |
| divisor_sign | input | 1 | Sign of the divisor (1 = negative) |
| quotient | output | DW | Quotient magnitude |
| remainder | output | VW | Remainder magnitude |
| quotient_sign | output | 1 | Sign of the quotient |
| remainder_sign | output | 1 | Sign of the remainder |
| div_by_zero | output | 1 | High when the divisor is zero |

## Verification
The checker re-evaluates its conditions whenever an input or output changes. It checks three things at all times:
- the division identity and the remainder bound for any non-zero divisor;
- the all-ones quotient whenever the zero flag is up;
- equality of the two result signs.

These checks only relate outputs to one another. Only the bench's scenarios can show that each result matches the independently computed quotient and remainder. That includes the exact value of the remainder under a zero divisor and the independence of the magnitudes from the sign inputs. For this the bench sweeps every dividend against every divisor under varied sign pairs, then adds random draws.

// File: rtl/div_pkg.sv
package div_pkg;

  // Difference bit of a one-bit full subtractor: a - b - bin
  function automatic logic sub_diff(input logic a, input logic b, input logic bin);
    return a ^ b ^ bin;
  endfunction

  // Borrow out of a one-bit full subtractor
  function automatic logic sub_borrow(input logic a, input logic b, input logic bin);
    return (~a & b) | (~(a ^ b) & bin);
  endfunction

  // Sign of a sign-magnitude result from its operand signs
  function automatic logic result_sign(input logic sa, input logic sd);
    return sa ^ sd;
  endfunction

endpackage

// File: rtl/div_cell.sv
module div_cell
  import div_pkg::*;
(
  input  logic s_in,    // partial remainder bit
  input  logic d_in,    // divisor bit
  input  logic b_in,    // borrow from lower column
  input  logic q_sel,   // row quotient bit: 1 keeps the difference
  output logic b_out,   // borrow to upper column
  output logic s_out,   // restored or reduced remainder bit
  output logic d_out    // divisor bit handed to the next row
);
  logic diff;

  always_comb begin
    diff  = sub_diff(s_in, d_in, b_in);
    b_out = sub_borrow(s_in, d_in, b_in);
    s_out = q_sel ? diff : s_in;
    d_out = d_in;
  end
endmodule

// File: rtl/div_row.sv
module div_row
  import div_pkg::*;
#(
  parameter int VW = 3
) (
  input  logic [VW:0]   part,       // trial remainder, one bit wider than divisor
  input  logic [VW-1:0] dvsr,
  output logic          q_bit,
  output logic [VW-1:0] rem_next,
  output logic [VW-1:0] dvsr_pass
);
  localparam int NB = VW + 1;

  logic [NB-1:0] borrow_chain;
  logic          top_borrow;

  assign borrow_chain[0] = 1'b0;

  for (genvar i = 0; i < VW; i++) begin : g_cell
    div_cell u_cell (
      .s_in  (part[i]),
      .d_in  (dvsr[i]),
      .b_in  (borrow_chain[i]),
      .q_sel (q_bit),
      .b_out (borrow_chain[i+1]),
      .s_out (rem_next[i]),
      .d_out (dvsr_pass[i])
    );
  end

  // Top position subtracts an implicit zero divisor bit; only its borrow matters
  assign top_borrow = sub_borrow(part[VW], 1'b0, borrow_chain[VW]);
  assign q_bit      = ~top_borrow;
endmodule

// File: rtl/div_array.sv
module div_array #(
  parameter int DW = 6,
  parameter int VW = 3
) (
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic [DW-1:0] quotient,
  output logic [VW-1:0] remainder,
  output logic          dvsr_zero
);
  logic [VW-1:0] rem_chain  [DW+1];
  logic [VW-1:0] dvsr_chain [DW+1];

  assign rem_chain[0]  = '0;
  assign dvsr_chain[0] = divisor;

  // Row k consumes dividend bit DW-1-k and yields the matching quotient bit
  for (genvar k = 0; k < DW; k++) begin : g_row
    div_row #(.VW(VW)) u_row (
      .part      ({rem_chain[k], dividend[DW-1-k]}),
      .dvsr      (dvsr_chain[k]),
      .q_bit     (quotient[DW-1-k]),
      .rem_next  (rem_chain[k+1]),
      .dvsr_pass (dvsr_chain[k+1])
    );
  end

  assign remainder = rem_chain[DW];
  // Zero test taken on the divisor as it leaves the last row
  assign dvsr_zero = (dvsr_chain[DW] == '0);
endmodule

// File: rtl/div_sign.sv
module div_sign
  import div_pkg::*;
#(
  parameter bit SIGN_EN = 1'b1
) (
  input  logic sa,
  input  logic sd,
  output logic sq,
  output logic sr
);
  if (SIGN_EN) begin : g_on
    logic s;
    assign s  = result_sign(sa, sd);
    assign sq = s;
    assign sr = s;
  end else begin : g_off
    logic unused_signs;
    assign unused_signs = sa ^ sd;
    assign sq = 1'b0 & unused_signs;
    assign sr = 1'b0;
  end
endmodule

// File: rtl/restoring_array_divider.sv
module restoring_array_divider #(
  parameter int DW      = 6,
  parameter int VW      = 3,
  parameter bit SIGN_EN = 1'b1
) (
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  input  logic          dividend_sign,
  input  logic          divisor_sign,
  output logic [DW-1:0] quotient,
  output logic [VW-1:0] remainder,
  output logic          quotient_sign,
  output logic          remainder_sign,
  output logic          div_by_zero
);
  // Named internal events, visible to the bound checker
  logic [DW-1:0] row_quotient_bits;
  logic [VW-1:0] final_remainder;
  logic          zero_seen;

  div_array #(.DW(DW), .VW(VW)) u_array (
    .dividend  (dividend),
    .divisor   (divisor),
    .quotient  (row_quotient_bits),
    .remainder (final_remainder),
    .dvsr_zero (zero_seen)
  );

  div_sign #(.SIGN_EN(SIGN_EN)) u_sign (
    .sa (dividend_sign),
    .sd (divisor_sign),
    .sq (quotient_sign),
    .sr (remainder_sign)
  );

  assign quotient    = row_quotient_bits;
  assign remainder   = final_remainder;
  assign div_by_zero = zero_seen;
endmodule

// File: rtl/div_checker.sv
module div_checker #(
  parameter int DW      = 6,
  parameter int VW      = 3,
  parameter bit SIGN_EN = 1'b1
) (
  input logic [DW-1:0] dividend,
  input logic [VW-1:0] divisor,
  input logic [DW-1:0] quotient,
  input logic [VW-1:0] remainder,
  input logic          quotient_sign,
  input logic          remainder_sign,
  input logic          div_by_zero
);
  localparam int PW = DW + VW;

  logic [PW-1:0] rebuilt;

  always_comb begin
    rebuilt = PW'(quotient) * PW'(divisor) + PW'(remainder);
    if (!div_by_zero) begin
      assert_remainder_bound_R3: assert (remainder < divisor)
        else $error("remainder %0d not below divisor %0d", remainder, divisor);
      assert_identity_R3: assert (rebuilt == PW'(dividend))
        else $error("q*d+r=%0d differs from dividend %0d", rebuilt, dividend);
    end
    if (div_by_zero) begin
      assert_zero_quotient_R5: assert (quotient == {DW{1'b1}})
        else $error("zero divisor gave quotient %0h", quotient);
    end
    if (SIGN_EN) begin
      assert_signs_equal_R6: assert (quotient_sign == remainder_sign)
        else $error("result signs differ");
    end
  end
endmodule

bind restoring_array_divider div_checker #(.DW(DW), .VW(VW), .SIGN_EN(SIGN_EN)) u_div_checker (
  .dividend       (dividend),
  .divisor        (divisor),
  .quotient       (quotient),
  .remainder      (remainder),
  .quotient_sign  (quotient_sign),
  .remainder_sign (remainder_sign),
  .div_by_zero    (div_by_zero)
);

// File: tb/tb_restoring_array_divider.sv
module tb_restoring_array_divider;
  localparam int DW = 6;
  localparam int VW = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic          rst_n;
  logic [DW-1:0] dividend;
  logic [VW-1:0] divisor;
  logic          dividend_sign, divisor_sign;
  logic [DW-1:0] quotient;
  logic [VW-1:0] remainder;
  logic          quotient_sign, remainder_sign, div_by_zero;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  restoring_array_divider dut (
    .dividend       (dividend),
    .divisor        (divisor),
    .dividend_sign  (dividend_sign),
    .divisor_sign   (divisor_sign),
    .quotient       (quotient),
    .remainder      (remainder),
    .quotient_sign  (quotient_sign),
    .remainder_sign (remainder_sign),
    .div_by_zero    (div_by_zero)
  );

  function automatic int ref_quot(int a, int d);
    if (d == 0) return (1 << DW) - 1;
    return a / d;
  endfunction

  function automatic int ref_rem(int a, int d);
    if (d == 0) return a % (1 << VW);
    return a % d;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (a=%0d d=%0d)", tag, act, exp, dividend, divisor);
    end
  endtask

  task automatic run_case(input int a, input int d, input bit sa, input bit sd);
    int eq, er;
    dividend      = DW'(a);
    divisor       = VW'(d);
    dividend_sign = sa;
    divisor_sign  = sd;
    @(posedge clk);
    #1;
    eq = ref_quot(a, d);
    er = ref_rem(a, d);
    if (d != 0) begin
      chk(int'(quotient) == eq, "R1 quotient (R7 signs ignored)", int'(quotient), eq);
      chk(int'(remainder) == er, "R2 remainder (R7 signs ignored)", int'(remainder), er);
      chk(int'(remainder) < d, "R3 remainder bound", int'(remainder), d - 1);
    end else begin
      chk(int'(quotient) == eq, "R5 zero-divisor quotient", int'(quotient), eq);
      chk(int'(remainder) == er, "R5 zero-divisor remainder", int'(remainder), er);
    end
    chk(div_by_zero == (d == 0), "R4 zero flag", int'(div_by_zero), int'(d == 0));
    chk(quotient_sign == (sa ^ sd), "R6 quotient sign", int'(quotient_sign), int'(sa ^ sd));
    chk(remainder_sign == (sa ^ sd), "R6 remainder sign", int'(remainder_sign), int'(sa ^ sd));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n         = 1'b0;
    dividend      = '0;
    divisor       = '0;
    dividend_sign = 1'b0;
    divisor_sign  = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    // Initial state with all-zero inputs: zero divisor behaviour (R4, R5)
    chk(div_by_zero == 1'b1, "R4 initial zero flag", int'(div_by_zero), 1);
    chk(int'(quotient) == (1 << DW) - 1, "R5 initial quotient", int'(quotient), (1 << DW) - 1);
    rst_n = 1'b1;

    // Directed corners
    run_case(63, 1, 1'b0, 1'b0);
    run_case(63, 7, 1'b1, 1'b0);
    run_case(0, 5, 1'b0, 1'b1);
    run_case(6, 7, 1'b1, 1'b1);
    run_case(42, 0, 1'b1, 1'b0);

    // Exhaustive sweep, sign pair rotating with the operands
    for (int a = 0; a < (1 << DW); a++) begin
      for (int d = 0; d < (1 << VW); d++) begin
        run_case(a, d, a[0], d[1]);
      end
    end

    // Random draws with a fixed seed
    void'($urandom(32'd20240612));
    for (int n = 0; n < 300; n++) begin
      int ra, rd;
      bit rs1, rs2;
      ra  = int'($urandom % (1 << DW));
      rd  = int'($urandom % (1 << VW));
      rs1 = 1'($urandom);
      rs2 = 1'($urandom);
      run_case(ra, rd, rs1, rs2);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule